// File: doc/BRIEF.md
# Integer ALU with Operation Decode and Branch Condition

This block is the execute unit of a simple 32-bit integer datapath. It takes two operands together with the instruction's opcode and function fields. It works out which arithmetic or logical operation the instruction needs, and it produces both a data result and a one-bit branch-taken flag. The operation comes from the function field for register-register instructions and from the opcode for register-immediate instructions. It is fixed to addition for loads and stores, and it becomes a comparison for conditional branches.

The datapath supplies the second operand already prepared. For immediate instructions this is the extended 16-bit immediate. For loads and stores it is the sign-extended offset, so the result is the effective address base plus offset. Both outputs are registered and appear one clock after the inputs are presented.

Top module: `alu_unit`

## Requirements
- R1: A synchronous active-high reset clears `result_q` and `cond_q` to 0 at the next rising clock edge.
- R2: Outside reset, `result_q` and `cond_q` reflect the inputs sampled at the previous rising clock edge, a latency of exactly one cycle.
- R3: With opcode 0x00, the function field selects the operation. The codes are 0x20 add, 0x22 subtract (a-b), 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, and 0x2A signed set-less-than, which gives 1 when a<b and 0 otherwise.
- R4: Each immediate opcode selects its operation on `src_a` and `src_b`, regardless of the function field. The codes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, and 0x0E xor.
- R5: Opcodes 0x23 (load) and 0x2B (store) always give `src_a + src_b`, whatever the function field holds.
- R6: Opcode 0x04 sets the branch flag when `src_a == src_b`. Opcode 0x05 sets it when they differ.
- R7: Opcode 0x06 sets the branch flag when `src_a`, read as signed, is less than or equal to zero. Opcode 0x07 sets it when `src_a` is greater than zero. `src_b` has no effect on either.
- R8: For every opcode other than 0x04 to 0x07, the branch flag is 0.
- R9: Addition and subtraction wrap modulo 2^32 and raise no overflow indication.
- R10: Branch opcodes, opcode 0x00 with an unlisted function code, and any unlisted opcode all give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | 32 | First operand (register value or base) |
| src_b | input | 32 | Second operand (register value or extended immediate/offset) |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| result_q | output | 32 | Registered ALU result |
| cond_q | output | 1 | Registered branch-taken condition |

## Verification
The assertions assume that `src_a`, `src_b`, `opcode` and `funct` hold known values at every rising edge, including the edges while reset is held. The assertions that use the previous cycle's inputs depend on this. The bench drives all four inputs from the start of reset and changes them only on falling edges, so every sampled value is defined and stable. Random opcodes are drawn mostly from the listed codes, with a share of arbitrary values so that the zero-result and zero-flag rules are also exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_BLEZ = 6'h06;
  localparam logic [OPC_W-1:0] OPC_BGTZ = 6'h07;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LW   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW   = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    OP_ZERO, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_SLT
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_NONE, BR_EQ, BR_NE, BR_LEZ, BR_GTZ
  } br_kind_e;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output alu_op_e          op,
  output br_kind_e         br
);
  alu_op_e fn_op;

  // level 2: function field, used only for register-register instructions
  always_comb begin
    unique case (funct)
      FN_ADD:  fn_op = OP_ADD;
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_XOR:  fn_op = OP_XOR;
      FN_NOR:  fn_op = OP_NOR;
      FN_SLT:  fn_op = OP_SLT;
      default: fn_op = OP_ZERO;
    endcase
  end

  // level 1: instruction class from the opcode
  always_comb begin
    op = OP_ZERO;
    br = BR_NONE;
    unique case (opcode)
      OPC_REG:          op = fn_op;
      OPC_ADDI:         op = OP_ADD;
      OPC_SLTI:         op = OP_SLT;
      OPC_ANDI:         op = OP_AND;
      OPC_ORI:          op = OP_OR;
      OPC_XORI:         op = OP_XOR;
      OPC_LW, OPC_SW:   op = OP_ADD;
      OPC_BEQ:          br = BR_EQ;
      OPC_BNE:          br = BR_NE;
      OPC_BLEZ:         br = BR_LEZ;
      OPC_BGTZ:         br = BR_GTZ;
      default:          op = OP_ZERO;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] sum, diff;
  logic             lt;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      OP_ADD:  y = sum;
      OP_SUB:  y = diff;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      OP_SLT:  y = {{(WIDTH-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_branch_cond.sv
module alu_branch_cond
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  br_kind_e         br,
  output logic             taken
);
  logic eq, a_le_zero;

  assign eq        = (a == b);
  assign a_le_zero = a[WIDTH-1] | (a == '0);

  always_comb begin
    unique case (br)
      BR_EQ:   taken = eq;
      BR_NE:   taken = ~eq;
      BR_LEZ:  taken = a_le_zero;
      BR_GTZ:  taken = ~a_le_zero;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [WIDTH-1:0] result_q,
  output logic             cond_q
);
  alu_op_e          op;
  br_kind_e         br;
  logic [WIDTH-1:0] y;
  logic             taken;

  alu_op_decode u_dec (.opcode(opcode), .funct(funct), .op(op), .br(br));

  alu_datapath #(.WIDTH(WIDTH)) u_dp (.a(src_a), .b(src_b), .op(op), .y(y));

  alu_branch_cond #(.WIDTH(WIDTH)) u_bc (.a(src_a), .b(src_b), .br(br), .taken(taken));

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      cond_q   <= 1'b0;
    end else begin
      result_q <= y;
      cond_q   <= taken;
    end
  end

  // R1: reset clears both outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_q == '0 && cond_q == 1'b0));

  // R5: loads and stores form base plus offset one cycle later
  assert_addr_add_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode) == OPC_LW || $past(opcode) == OPC_SW) && !$past(rst)
      |-> result_q == $past(src_a) + $past(src_b));

  // R6: equality branch flag follows operand comparison
  assert_beq_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode) == OPC_BEQ) && !$past(rst)
      |-> cond_q == ($past(src_a) == $past(src_b)));

  // R8: no branch flag for non-branch opcodes
  assert_flag_nonbranch_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode) < OPC_BEQ || $past(opcode) > OPC_BGTZ) && !$past(rst)
      |-> !cond_q);

  // R10: branches produce a zero result
  assert_branch_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode) >= OPC_BEQ && $past(opcode) <= OPC_BGTZ) && !$past(rst)
      |-> result_q == '0);
endmodule

// File: tb/alu_unit_bench.sv
module alu_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_a, src_b;
  logic [5:0]  opcode, funct;
  logic [31:0] result_q;
  logic        cond_q;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_unit u_alu_unit (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
    .opcode(opcode), .funct(funct), .result_q(result_q), .cond_q(cond_q)
  );

  function automatic logic [31:0] ref_fn(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h26: return a ^ b;
      6'h27: return ~(a | b);
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_res(input logic [5:0] o, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (o)
      6'h00: return ref_fn(f, a, b);
      6'h08: return ref_fn(6'h20, a, b);
      6'h0A: return ref_fn(6'h2A, a, b);
      6'h0C: return ref_fn(6'h24, a, b);
      6'h0D: return ref_fn(6'h25, a, b);
      6'h0E: return ref_fn(6'h26, a, b);
      6'h23, 6'h2B: return a + b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_cond(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      6'h04: return a == b;
      6'h05: return a != b;
      6'h06: return $signed(a) <= 0;
      6'h07: return $signed(a) > 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string res_tag(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'h00: return (ref_fn(f, 32'd5, 32'd3) == 32'd0 && f != 6'h24 && f != 6'h2A) ? "R10" : "R3";
      6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: return "R4";
      6'h23, 6'h2B: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string cond_tag(input logic [5:0] o);
    case (o)
      6'h04, 6'h05: return "R6";
      6'h06, 6'h07: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register, R2)
  task automatic run_op(input logic [5:0] o, input logic [5:0] f, input logic [31:0] a,
                        input logic [31:0] b, input string rtag);
    opcode = o; funct = f; src_a = a; src_b = b;
    @(negedge clk);
    check(rtag, result_q, ref_res(o, f, a, b));
    check(cond_tag(o), {31'd0, cond_q}, {31'd0, ref_cond(o, a, b)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] legal [12];
    legal = '{6'h00, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h23, 6'h2B};
    void'($urandom(32'd2024));
    rst = 1'b1; src_a = 32'hDEAD_BEEF; src_b = 32'h1234_5678; opcode = 6'h00; funct = 6'h20;
    repeat (3) @(negedge clk);
    check("R1", result_q, 32'd0);
    check("R1", {31'd0, cond_q}, 32'd0);
    opcode = 6'h04; src_b = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R1", {31'd0, cond_q}, 32'd0);
    rst = 1'b0;

    // R2: back-to-back operations each appear exactly one edge later
    run_op(6'h00, 6'h20, 32'd10, 32'd20, "R2");
    run_op(6'h00, 6'h22, 32'd10, 32'd20, "R2");
    // R9 wrap cases
    run_op(6'h00, 6'h20, 32'hFFFF_FFFF, 32'd1, "R9");
    run_op(6'h00, 6'h22, 32'd0, 32'd1, "R9");
    run_op(6'h08, 6'h00, 32'h7FFF_FFFF, 32'd1, "R9");
    // R3 signed set-less-than and nor
    run_op(6'h00, 6'h2A, 32'hFFFF_FFFF, 32'd1, "R3");
    run_op(6'h00, 6'h2A, 32'd1, 32'hFFFF_FFFF, "R3");
    run_op(6'h00, 6'h27, 32'd0, 32'd0, "R3");
    // R4 immediate slt with negative immediate
    run_op(6'h0A, 6'h20, 32'h8000_0000, 32'hFFFF_FFF0, "R4");
    // R5 load/store ignore funct
    run_op(6'h23, 6'h22, 32'h0000_1000, 32'hFFFF_FFFC, "R5");
    run_op(6'h2B, 6'h27, 32'h0000_2000, 32'h0000_0010, "R5");
    // R6 equal / not equal
    run_op(6'h04, 6'h00, 32'hABCD_0000, 32'hABCD_0000, "R10");
    run_op(6'h05, 6'h00, 32'hABCD_0000, 32'hABCD_0000, "R10");
    run_op(6'h05, 6'h00, 32'd1, 32'd2, "R10");
    // R7 zero tests ignore src_b
    run_op(6'h06, 6'h00, 32'd0, 32'd5, "R10");
    run_op(6'h06, 6'h00, 32'h8000_0000, 32'h8000_0000, "R10");
    run_op(6'h06, 6'h00, 32'd1, 32'hFFFF_FFFF, "R10");
    run_op(6'h07, 6'h00, 32'd1, 32'd0, "R10");
    run_op(6'h07, 6'h00, 32'h7FFF_FFFF, 32'd9, "R10");
    run_op(6'h07, 6'h00, 32'd0, 32'hFFFF_FFFF, "R10");
    // R10 unlisted function and opcode; R8 flag stays low
    run_op(6'h00, 6'h00, 32'd7, 32'd7, "R10");
    run_op(6'h02, 6'h20, 32'd7, 32'd7, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] o, f;
      logic [31:0] a, b;
      o = ($urandom % 8 == 0) ? 6'($urandom) : legal[$urandom % 12];
      f = ($urandom % 4 == 0) ? 6'($urandom) : 6'h20 + 6'($urandom % 11);
      case ($urandom % 4)
        0: a = 32'd0;
        1: a = {$urandom % 2 == 0, 31'($urandom)};
        default: a = $urandom;
      endcase
      b = ($urandom % 5 == 0) ? a : $urandom;
      run_op(o, f, a, b, res_tag(o, f));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule